// File: doc/BRIEF.md
# Flash Thermometer Encoder with Bubble Rejection

This block is the digital back end of a flash converter stage. A bank of `2^BITS - 1` comparators produces a thermometer word: ideally every comparator below the input level reads 1 and every one above it reads 0. The block turns that word into a `BITS`-wide binary code. A comparator whose input sits close to its reference can produce an indeterminate level. For that reason the raw word is registered before any decoding.

An offset in one comparator can flip a single bit inside the thermometer word. The block tolerates such a bubble. It accepts an edge only where two consecutive ones sit directly below a zero. When more than one edge qualifies, it keeps only the highest. It encodes the selected position into Gray code and registers it, so that an uncertain edge can upset at most one intermediate bit. The final stage converts the Gray code to binary and registers it. A valid strobe travels with the data through all three stages.

The default parameter (`BITS = 4`, 15 inputs) serves a coarse stage. The same module with `BITS = 3` (7 inputs) serves a fine stage. The design is a fixed three-register pipeline and contains no control state machine.

Top module: `thermo_gray_encoder`

## Requirements
- R1: `code_vld` equals `therm_vld` as sampled three rising edges earlier, so a word that is presented with its strobe high appears on `code_out` after exactly three clock edges.
- R2: A clean thermometer word, in which bits 0 to k-1 are 1 and all higher bits are 0, yields code k for every k from 0 to `2^BITS - 1`. The all-zero word gives 0 and the all-ones word gives full scale.
- R3: A single stray 1 above the true edge is ignored when at least one 0 separates it from the edge. For example, the coarse word 0x0047 gives 3.
- R4: A single 0 inside the run of ones is ignored when it lies three or more positions below the top edge. For example, the coarse words 0x0FDF and 0x7FFE give 12 and 15.
- R5: In general the code is the largest c in 0..2^BITS-1 for which bits c-2 and c-1 are both 1 and bit c is 0. Positions below bit 0 count as 1 and position 2^BITS-1 counts as 0. For example, the coarse words 0x1E07 and 0x002F give 13 and 4.
- R6: A synchronous active-high `rst` sampled at a rising edge clears `code_out` and `code_vld` to 0 at that edge.
- R7: When the strobe is low, no stage loads new data. `code_out` then keeps the last valid code and ignores the thermometer bits presented with a low strobe.
- R8: The intermediate register holds the Gray code `b ^ (b >> 1)` of the selected position. The output is that Gray value converted back to binary, so the selected position appears on `code_out` unchanged.
- R9: With `BITS = 3` the block accepts a 7-bit word and follows the same rules, R1 to R8, for codes 0 to 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| therm_in | input | 2^BITS-1 | Raw comparator outputs, bit 0 is the lowest threshold |
| therm_vld | input | 1 | Strobe marking a thermometer word to convert |
| code_out | output | BITS | Binary output code |
| code_vld | output | 1 | Strobe marking a new code on `code_out` |

## Verification
The bench targets bubble placement. A zero two positions below the top edge must move the code down, because a design with a two-input edge detector would keep it. A zero three positions below must leave the code unchanged, and a stray one above the edge must not raise the code, which a plain ones count or a plain priority encoder would do. It also checks both extremes: all-zero and all-ones, where a missing virtual bit below position 0 or above the top would produce no edge or a wrong one. A gap in the strobe must hold the last code, which separates a design whose stages load every cycle. The same rules are applied to the 7-bit fine instance.

// File: rtl/thermo_enc_pkg.sv
package thermo_enc_pkg;

    // Reflected binary (Gray) code of an integer.
    function automatic int unsigned to_gray(input int unsigned v);
        return v ^ (v >> 1);
    endfunction

endpackage

// File: rtl/thermo_capture.sv
// First pipeline stage: registers the raw comparator outputs so that a
// marginal comparator level has a full cycle to resolve before decoding.
module thermo_capture #(
    parameter int TW = 15
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [TW-1:0] d_in,
    input  logic          v_in,
    output logic [TW-1:0] d_out,
    output logic          v_out
);

    always_ff @(posedge clk) begin
        if (rst) begin
            d_out <= '0;
            v_out <= 1'b0;
        end else begin
            v_out <= v_in;
            if (v_in) begin
                d_out <= d_in;
            end
        end
    end

    AST_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !v_in |=> $stable(d_out)); // R7

endmodule

// File: rtl/thermo_gray_stage.sv
// Second pipeline stage: three-input edge detection, highest-edge
// selection and one-hot to Gray encoding, followed by a register.
module thermo_gray_stage #(
    parameter int BITS = 4,
    parameter int TW   = (1 << BITS) - 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [TW-1:0]   therm,
    input  logic            v_in,
    output logic [BITS-1:0] gray_q,
    output logic            v_out
);

    localparam int EW = TW + 3;   // word extended by two ones below, one zero above

    logic [EW-1:0] ext;
    logic [TW:0]   flag;          // flag[c]: edge for code c
    logic [TW:0]   sel;           // highest flag only
    logic [BITS-1:0] gray_d;

    assign ext = {1'b0, therm, 2'b11};

    // One three-input gate per candidate code.
    generate
        for (genvar c = 0; c <= TW; c++) begin : g_edge
            assign flag[c] = ext[c] & ext[c+1] & ~ext[c+2];
        end
    endgenerate

    // Keep only the topmost flagged edge.
    always_comb begin
        logic found;
        sel   = '0;
        found = 1'b0;
        for (int c = TW; c >= 0; c--) begin
            if (flag[c] && !found) begin
                sel[c] = 1'b1;
                found  = 1'b1;
            end
        end
    end

    // Column mask: which codes have Gray bit k set.
    function automatic logic [TW:0] col_mask(input int k);
        logic [TW:0] m;
        int unsigned g;
        m = '0;
        for (int c = 0; c <= TW; c++) begin
            g    = thermo_enc_pkg::to_gray(unsigned'(c));
            m[c] = g[k];
        end
        return m;
    endfunction

    // Each Gray bit is an OR over the one-hot lines whose code sets it.
    generate
        for (genvar k = 0; k < BITS; k++) begin : g_gray
            localparam logic [TW:0] MASK = col_mask(k);
            assign gray_d[k] = |(sel & MASK);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            gray_q <= '0;
            v_out  <= 1'b0;
        end else begin
            v_out <= v_in;
            if (v_in) begin
                gray_q <= gray_d;
            end
        end
    end

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        (|flag) |-> $onehot(sel)); // R5

    AST_SEL_TOPMOST: assert property (@(posedge clk) disable iff (rst)
        (flag & ~(sel | (sel - 1'b1))) == '0); // R5

    AST_GRAY_HOLD: assert property (@(posedge clk) disable iff (rst)
        !v_in |=> $stable(gray_q)); // R7

endmodule

// File: rtl/gray_to_bin_stage.sv
// Third pipeline stage: Gray to binary by an XOR chain from the MSB down,
// then the output register.
module gray_to_bin_stage #(
    parameter int BITS = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [BITS-1:0] gray_in,
    input  logic            v_in,
    output logic [BITS-1:0] code_q,
    output logic            v_out
);

    logic [BITS-1:0] bin_d;

    assign bin_d[BITS-1] = gray_in[BITS-1];
    generate
        for (genvar k = BITS - 2; k >= 0; k--) begin : g_chain
            assign bin_d[k] = gray_in[k] ^ bin_d[k+1];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= '0;
            v_out  <= 1'b0;
        end else begin
            v_out <= v_in;
            if (v_in) begin
                code_q <= bin_d;
            end
        end
    end

    AST_BIN_FROM_GRAY: assert property (@(posedge clk) disable iff (rst)
        v_in |=> ((code_q ^ (code_q >> 1)) == $past(gray_in))); // R8

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !v_in |=> $stable(code_q)); // R7

endmodule

// File: rtl/thermo_gray_encoder.sv
// Flash thermometer encoder: capture -> edge select / Gray -> binary out.
module thermo_gray_encoder #(
    parameter  int BITS = 4,
    localparam int TW   = (1 << BITS) - 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [TW-1:0]   therm_in,
    input  logic            therm_vld,
    output logic [BITS-1:0] code_out,
    output logic            code_vld
);

    logic [TW-1:0]   cap_therm;
    logic            cap_vld;
    logic [BITS-1:0] mid_gray;
    logic            mid_vld;

    thermo_capture #(
        .TW (TW)
    ) u_capture (
        .clk   (clk),
        .rst   (rst),
        .d_in  (therm_in),
        .v_in  (therm_vld),
        .d_out (cap_therm),
        .v_out (cap_vld)
    );

    thermo_gray_stage #(
        .BITS (BITS),
        .TW   (TW)
    ) u_gray (
        .clk    (clk),
        .rst    (rst),
        .therm  (cap_therm),
        .v_in   (cap_vld),
        .gray_q (mid_gray),
        .v_out  (mid_vld)
    );

    gray_to_bin_stage #(
        .BITS (BITS)
    ) u_bin (
        .clk     (clk),
        .rst     (rst),
        .gray_in (mid_gray),
        .v_in    (mid_vld),
        .code_q  (code_out),
        .v_out   (code_vld)
    );

    // Edges since reset, saturating at 3, so the latency check never
    // looks back into a reset cycle.
    logic [1:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst) begin
            since_rst <= '0;
        end else if (since_rst != 2'd3) begin
            since_rst <= since_rst + 2'd1;
        end
    end

    AST_VLD_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd3) |-> (code_vld == $past(therm_vld, 3))); // R1

endmodule

// File: tb/thermo_gray_encoder_tb.sv
module thermo_gray_encoder_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [14:0] therm_c = '0;
    logic [6:0]  therm_f = '0;
    logic        vld = 1'b0;
    logic [3:0]  code_c;
    logic [2:0]  code_f;
    logic        vld_c, vld_f;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    thermo_gray_encoder #(.BITS(4)) u_dut (
        .clk(clk), .rst(rst), .therm_in(therm_c), .therm_vld(vld),
        .code_out(code_c), .code_vld(vld_c));

    thermo_gray_encoder #(.BITS(3)) u_dut_fine (
        .clk(clk), .rst(rst), .therm_in(therm_f), .therm_vld(vld),
        .code_out(code_f), .code_vld(vld_f));

    // Expected-value history: index 1 = last driven, 3 = driven three cycles ago.
    logic        h_v [1:3];
    int          h_c [1:3];
    int          h_f [1:3];
    string       h_t [1:3];
    int          hold_c, hold_f;

    // Rule of R5, evaluated from the requirement text.
    function automatic int ref_code(input logic [14:0] t, input int tw);
        int best = 0;
        for (int c = 0; c <= tw; c++) begin
            bit lo2, lo1, here;
            if (c - 2 < 0) lo2 = 1'b1; else lo2 = t[c-2];
            if (c - 1 < 0) lo1 = 1'b1; else lo1 = t[c-1];
            if (c >= tw)   here = 1'b0; else here = t[c];
            if (lo2 && lo1 && !here) best = c;
        end
        return best;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_hist();
        for (int i = 1; i <= 3; i++) begin
            h_v[i] = 1'b0; h_c[i] = 0; h_f[i] = 0; h_t[i] = "R7";
        end
        hold_c = 0;
        hold_f = 0;
    endtask

    task automatic check_out();
        string tag;
        if (h_v[3]) begin
            hold_c = h_c[3];
            hold_f = h_f[3];
            tag = h_t[3];
        end else begin
            tag = "R7";
        end
        chk(vld_c === h_v[3], "R1 coarse valid", int'(vld_c), int'(h_v[3]));
        chk(vld_f === h_v[3], "R9/R1 fine valid", int'(vld_f), int'(h_v[3]));
        chk(int'(code_c) == hold_c, {tag, "/R8 coarse code"}, int'(code_c), hold_c);
        chk(int'(code_f) == hold_f, {"R9/", tag, " fine code"}, int'(code_f), hold_f);
    endtask

    task automatic step(input logic [14:0] cv, input logic [6:0] fv,
                        input logic v, input string tag);
        @(negedge clk);
        check_out();
        for (int i = 3; i > 1; i--) begin
            h_v[i] = h_v[i-1]; h_c[i] = h_c[i-1]; h_f[i] = h_f[i-1]; h_t[i] = h_t[i-1];
        end
        h_v[1] = v;
        h_c[1] = ref_code(cv, 15);
        h_f[1] = ref_code({8'd0, fv}, 7);
        h_t[1] = tag;
        therm_c = cv;
        therm_f = fv;
        vld     = v;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        vld = 1'b0;
        @(negedge clk);
        chk(code_c == 4'd0 && vld_c == 1'b0, "R6 coarse reset", int'({vld_c, code_c}), 0);
        chk(code_f == 3'd0 && vld_f == 1'b0, "R6 fine reset", int'({vld_f, code_f}), 0);
        rst = 1'b0;
        clear_hist();
    endtask

    initial begin
        int unsigned seed_init;
        seed_init = $urandom(32'd20240611);
        clear_hist();
        repeat (3) @(negedge clk);
        do_reset();

        // R2: every clean code, both instances
        for (int k = 0; k <= 15; k++) begin
            step(15'((32'd1 << k) - 1), 7'((32'd1 << (k % 8)) - 1), 1'b1, "R2");
        end

        // R3: stray ones above the edge
        step(15'h0047, 7'b0010001, 1'b1, "R3");   // expect 3 / 1
        step(15'h0020, 7'b1000011, 1'b1, "R3");   // expect 0 / 2

        // R4: holes far below the top edge
        step(15'h0FDF, 7'b1111011, 1'b1, "R4");   // expect 12 / 7
        step(15'h7FFE, 7'b0111110, 1'b1, "R4");   // expect 15 / 6

        // R5: several edges, hole right under the top
        step(15'h1E07, 7'b0001100, 1'b1, "R5");   // expect 13 / 4
        step(15'h002F, 7'b0010111, 1'b1, "R5");   // expect 4 / 3

        // R7: strobe low with changing words must not disturb the output
        step(15'h00FF, 7'b0001111, 1'b1, "R2");
        step(15'h7FFF, 7'b1111111, 1'b0, "R7");
        step(15'h0000, 7'b0000000, 1'b0, "R7");
        step(15'h1234, 7'b1010101, 1'b0, "R7");
        step(15'h0003, 7'b0000011, 1'b1, "R2");

        // R6: reset in mid-stream after valid data
        step(15'h3FFF, 7'b0111111, 1'b1, "R2");
        do_reset();

        // Random words, some with one flipped bit, random strobe gaps
        for (int n = 0; n < 400; n++) begin
            int kc = int'($urandom % 16);
            int kf = int'($urandom % 8);
            logic [14:0] cv = 15'((32'd1 << kc) - 1);
            logic [6:0]  fv = 7'((32'd1 << kf) - 1);
            bit flip = ($urandom % 3) == 0;
            if (flip) begin
                cv[$urandom % 15] ^= 1'b1;
                fv[$urandom % 7]  ^= 1'b1;
            end
            step(cv, fv, ($urandom % 5) != 0, flip ? "R5" : "R2");
        end

        // Flush
        for (int n = 0; n < 4; n++) step(15'h0, 7'h0, 1'b0, "R7");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R1 watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule